// File: doc/BRIEF.md
# Configuration Space Register Responder

This block answers configuration-space accesses for a simple endpoint function. Each access gives a 12-bit register offset, an access width, a write strobe and write data. The block returns read data for that offset and width. Writes are taken at the rising clock edge.

The block holds three writable registers: a 16-bit command register and two live base address registers. BAR0 decodes one byte of I/O space. BAR1 decodes 256 bytes of 32-bit memory space. Four further base address slots are hard-wired to zero. The block also returns fixed identification values. Writing all ones to a live BAR starts the sizing handshake: on the next read the BAR returns its size mask.

Two read-only capability chains sit in the register space. The standard chain runs power management, then PCI Express, then MSI-X. The extended chain runs error reporting, then virtual channel, then serial number. Only the chain headers are present; the capability bodies are not. Every offset the block does not implement reads as zero.

Top module: `cfg_space_responder`

## Requirements
- R1: Synchronous active-low reset clears the command register and both live BARs. After reset, offsets 0x004, 0x010 and 0x014 all read 0.
- R2: Offset 0x000 reads the vendor ID (default 0xABCD). Offset 0x002 reads the device ID (default 0x5A5A).
- R3: A write at offset 0x004 stores wr_data[15:0] in the command register. A later read at 0x004 returns that value unchanged.
- R4: Reads at offset 0x00A depend on width. A byte read returns the subclass (default 0x34). A word or dword read returns the class code in bits 15:8 and the subclass in bits 7:0 (0x1234). A read at 0x00B returns the class code alone (0x12).
- R5: A write at 0x010 (BAR0) or 0x014 (BAR1) stores wr_data with bit 0 forced to the BAR type: 1 for BAR0 (I/O), 0 for BAR1 (memory). While bits 31:1 are not all ones, a read returns the stored value.
- R6: A live BAR whose stored bits 31:1 are all ones reads its size mask. The mask is ~(size-1), limited to the address bits. BAR0 limits with 0xFFFFFFFC and sets bit 0, giving 0xFFFFFFFD. BAR1 limits with 0xFFFFFFF0 and keeps the type bits zero, giving 0xFFFFFF00.
- R7: The BAR slots at 0x018, 0x01C, 0x020 and 0x024 ignore writes and always read 0.
- R8: Offset 0x034 reads the power-management offset (0x40). Each standard header holds the next offset in bits 15:8 and the ID in bits 7:0: 0x40 reads 0x5001 and 0x50 reads 0x7010. The MSI-X header at 0x70 reads 0x11. Reading header+1 returns the next pointer alone: 0x41 gives 0x50, 0x51 gives 0x70, 0x71 gives 0.
- R9: Each extended header holds the next offset in bits 31:20 and the ID in bits 15:0. 0x100 reads 0x14000001, 0x140 reads 0x18000002 and 0x180 reads 0x00000003.
- R10: Any offset the block does not implement reads 0. A write to such an offset changes neither the command register nor any BAR.
- R11: The size input selects the read width: 0 is byte, 1 is word, 2 or 3 is dword. A byte read returns only bits 7:0 of the register value and a word read only bits 15:0. All higher bits read 0.
- R12: rd_data is a combinational function of offset, size and stored state. A write takes effect at the clock edge, so in the write cycle a read of the same offset still shows the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| offset | input | 12 | Byte offset in configuration space |
| size | input | 2 | Access width: 0 byte, 1 word, 2/3 dword |
| wr_en | input | 1 | Write strobe, taken at the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for offset and size |

## Verification
A register write and a readback of that same register can occur in one cycle, because the read path stays live while wr_en is high. The bench provokes this by holding a write to BAR1 at offset 0x014 and sampling rd_data in two places. Before the clock edge it must still show BAR1's sizing mask, 0xFFFFFF00. After the edge it must show the newly stored base. A design that forwards write data into the read path, or that updates late, fails one of the two samples.

// File: rtl/cfgsp_pkg.sv
// Package: shared encodings for the configuration space responder.
// Assumes 12-bit offsets and a 2-bit access width code.
package cfgsp_pkg;

    // Access width encodings on the size input.
    localparam logic [1:0] ACC_BYTE  = 2'd0;
    localparam logic [1:0] ACC_WORD  = 2'd1;

    // Fixed register offsets in the header.
    localparam logic [11:0] OFS_VENDOR   = 12'h000;
    localparam logic [11:0] OFS_DEVICE   = 12'h002;
    localparam logic [11:0] OFS_COMMAND  = 12'h004;
    localparam logic [11:0] OFS_CLASS    = 12'h00A;
    localparam logic [11:0] OFS_CLASS_HI = 12'h00B;
    localparam logic [11:0] OFS_BAR_BASE = 12'h010;
    localparam logic [11:0] OFS_CAP_PTR  = 12'h034;

    // Capability identifiers.
    localparam logic [7:0]  CAPID_PM   = 8'h01;
    localparam logic [7:0]  CAPID_PCIE = 8'h10;
    localparam logic [7:0]  CAPID_MSIX = 8'h11;
    localparam logic [15:0] XCAPID_AER = 16'h0001;
    localparam logic [15:0] XCAPID_VC  = 16'h0002;
    localparam logic [15:0] XCAPID_DSN = 16'h0003;

    // Returns the lane mask for an access width.
    function automatic logic [31:0] width_mask(input logic [1:0] sz);
        case (sz)
            ACC_BYTE: width_mask = 32'h0000_00FF;
            ACC_WORD: width_mask = 32'h0000_FFFF;
            default:  width_mask = 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/cfgsp_bar_bank.sv
// Module: bank of base address registers with sizing readback.
// Slots 0 and 1 are live (slot 0 I/O, slot 1 32-bit memory).
// The remaining slots are tied to zero.
// Assumes the caller raises wr_en only for an aligned BAR offset.
module cfgsp_bar_bank #(
    parameter int unsigned NUM_BARS      = 6,
    parameter int unsigned BAR0_BYTES    = 1,
    parameter int unsigned BAR1_BYTES    = 256,
    parameter logic [31:0] IO_ADDR_MASK  = 32'hFFFF_FFFC,
    parameter logic [31:0] MEM_ADDR_MASK = 32'hFFFF_FFF0,
    localparam int unsigned IDX_W        = $clog2(NUM_BARS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [31:0]                   wr_data,
    output logic [NUM_BARS-1:0][31:0]     bar_rd
);

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        if (g < 2) begin : g_live
            localparam logic        IS_IO = (g == 0);
            localparam logic [31:0] SZ    = (g == 0) ? 32'(BAR0_BYTES) : 32'(BAR1_BYTES);
            localparam logic [31:0] MASK  = IS_IO ? (((~(SZ - 32'd1)) & IO_ADDR_MASK) | 32'd1)
                                                  : ((~(SZ - 32'd1)) & MEM_ADDR_MASK);
            logic [31:0] bar_q;
            logic [31:0] bar_d;
            logic        hit;

            // Selects this slot for the current write.
            assign hit = wr_en && (wr_idx == IDX_W'(g));

            // Forces the read-only space bit to the slot type.
            always_comb begin
                bar_d    = wr_data;
                bar_d[0] = IS_IO;
            end

            // Holds the BAR; cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n)   bar_q <= '0;
                else if (hit) bar_q <= bar_d;
            end

            // Returns the size mask during sizing, else the stored value.
            assign bar_rd[g] = (&bar_q[31:1]) ? MASK : bar_q;

            // R5: after any write the space bit matches the slot type.
            a_r5_space_bit: assert property (@(posedge clk) disable iff (!rst_n)
                hit |=> bar_q[0] == IS_IO);

            // R6: any nonzero readback carries the slot's type bit.
            a_r6_read_type: assert property (@(posedge clk) disable iff (!rst_n)
                (bar_rd[g] != 32'd0) |-> (bar_rd[g][0] == IS_IO));
        end else begin : g_tied
            assign bar_rd[g] = 32'd0;
        end
    end

endmodule

// File: rtl/cfgsp_cap_chain.sv
// Module: read-only headers of the standard and extended capability chains.
// Purely combinational. hit is high when offset matches a header byte.
// Assumes all offsets are distinct and the extended ones are at or above 0x100.
module cfgsp_cap_chain
    import cfgsp_pkg::*;
#(
    parameter logic [11:0] PM_OFS   = 12'h040,
    parameter logic [11:0] PCIE_OFS = 12'h050,
    parameter logic [11:0] MSIX_OFS = 12'h070,
    parameter logic [11:0] AER_OFS  = 12'h100,
    parameter logic [11:0] VC_OFS   = 12'h140,
    parameter logic [11:0] DSN_OFS  = 12'h180
) (
    input  logic [11:0] offset,
    output logic        hit,
    output logic [31:0] val
);

    localparam logic [11:0] PM_NXT   = PM_OFS + 12'd1;
    localparam logic [11:0] PCIE_NXT = PCIE_OFS + 12'd1;
    localparam logic [11:0] MSIX_NXT = MSIX_OFS + 12'd1;

    // Decodes the header offset into its fixed content.
    always_comb begin
        hit = 1'b1;
        val = 32'd0;
        case (offset)
            OFS_CAP_PTR: val = {24'd0, PM_OFS[7:0]};
            PM_OFS:      val = {16'd0, PCIE_OFS[7:0], CAPID_PM};
            PM_NXT:      val = {24'd0, PCIE_OFS[7:0]};
            PCIE_OFS:    val = {16'd0, MSIX_OFS[7:0], CAPID_PCIE};
            PCIE_NXT:    val = {24'd0, MSIX_OFS[7:0]};
            MSIX_OFS:    val = {24'd0, CAPID_MSIX};
            MSIX_NXT:    val = 32'd0;
            AER_OFS:     val = {VC_OFS, 4'h0, XCAPID_AER};
            VC_OFS:      val = {DSN_OFS, 4'h0, XCAPID_VC};
            DSN_OFS:     val = {12'd0, 4'h0, XCAPID_DSN};
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cfg_space_responder.sv
// Module: configuration space responder for a simple endpoint function.
// Reads are combinational. Writes are taken at the rising edge.
// Assumes one access per cycle and a caller that holds offset stable.
module cfg_space_responder
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'hABCD,
    parameter logic [15:0] DEVICE_ID  = 16'h5A5A,
    parameter logic [7:0]  CLASS_CODE = 8'h12,
    parameter logic [7:0]  SUBCLASS   = 8'h34,
    parameter int unsigned NUM_BARS   = 6,
    parameter int unsigned BAR0_BYTES = 1,
    parameter int unsigned BAR1_BYTES = 256,
    parameter logic [11:0] PM_OFS     = 12'h040,
    parameter logic [11:0] PCIE_OFS   = 12'h050,
    parameter logic [11:0] MSIX_OFS   = 12'h070,
    parameter logic [11:0] AER_OFS    = 12'h100,
    parameter logic [11:0] VC_OFS     = 12'h140,
    parameter logic [11:0] DSN_OFS    = 12'h180
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [11:0] offset,
    input  logic [1:0]  size,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data
);

    localparam int unsigned IDX_W   = $clog2(NUM_BARS);
    localparam logic [11:0] BAR_END = OFS_BAR_BASE + 12'(4 * NUM_BARS);

    logic [15:0]                cmd_q;
    logic                       bar_sel;
    logic [IDX_W-1:0]           bar_idx;
    logic [NUM_BARS-1:0][31:0]  bar_rd;
    logic                       cap_hit;
    logic [31:0]                cap_val;
    logic [31:0]                rd_raw;

    // Finds an aligned BAR offset and its slot number.
    assign bar_sel = (offset >= OFS_BAR_BASE) && (offset < BAR_END) && (offset[1:0] == 2'b00);
    assign bar_idx = IDX_W'((offset - OFS_BAR_BASE) >> 2);

    // Holds the command register.
    always_ff @(posedge clk) begin
        if (!rst_n)                               cmd_q <= '0;
        else if (wr_en && offset == OFS_COMMAND)  cmd_q <= wr_data[15:0];
    end

    cfgsp_bar_bank #(
        .NUM_BARS   (NUM_BARS),
        .BAR0_BYTES (BAR0_BYTES),
        .BAR1_BYTES (BAR1_BYTES)
    ) u_bars (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en && bar_sel),
        .wr_idx  (bar_idx),
        .wr_data (wr_data),
        .bar_rd  (bar_rd)
    );

    cfgsp_cap_chain #(
        .PM_OFS   (PM_OFS),
        .PCIE_OFS (PCIE_OFS),
        .MSIX_OFS (MSIX_OFS),
        .AER_OFS  (AER_OFS),
        .VC_OFS   (VC_OFS),
        .DSN_OFS  (DSN_OFS)
    ) u_caps (
        .offset (offset),
        .hit    (cap_hit),
        .val    (cap_val)
    );

    // Selects the register addressed by offset before width masking.
    always_comb begin
        rd_raw = 32'd0;
        if (cap_hit) begin
            rd_raw = cap_val;
        end else begin
            case (offset)
                OFS_VENDOR:   rd_raw = {16'd0, VENDOR_ID};
                OFS_DEVICE:   rd_raw = {16'd0, DEVICE_ID};
                OFS_COMMAND:  rd_raw = {16'd0, cmd_q};
                OFS_CLASS:    rd_raw = (size == ACC_BYTE) ? {24'd0, SUBCLASS}
                                                          : {16'd0, CLASS_CODE, SUBCLASS};
                OFS_CLASS_HI: rd_raw = {24'd0, CLASS_CODE};
                default:      if (bar_sel) rd_raw = bar_rd[bar_idx];
            endcase
        end
    end

    // Trims the result to the access width.
    assign rd_data = rd_raw & width_mask(size);

    // R1: reset leaves the command register cleared.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> cmd_q == 16'd0);

    // R3: a command write is stored exactly.
    a_r3_cmd_store: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset == OFS_COMMAND) |=> cmd_q == $past(wr_data[15:0]));

    // R10: writes elsewhere leave the command register alone.
    a_r10_cmd_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && offset != OFS_COMMAND) |=> cmd_q == $past(cmd_q));

endmodule

// File: tb/cfg_space_responder_test.sv
module cfg_space_responder_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 37;

    // {req[7:0], wr, offset[11:0], size[1:0], data[31:0], expect[31:0]}
    localparam logic [86:0] VEC [NV] = '{
        {8'd2,  1'b0, 12'h000, 2'd2, 32'h0, 32'h0000ABCD},   // R2 vendor
        {8'd2,  1'b0, 12'h002, 2'd1, 32'h0, 32'h00005A5A},   // R2 device
        {8'd3,  1'b1, 12'h004, 2'd1, 32'h00000147, 32'h0},   // R3 write
        {8'd3,  1'b0, 12'h004, 2'd1, 32'h0, 32'h00000147},   // R3 readback
        {8'd11, 1'b0, 12'h004, 2'd0, 32'h0, 32'h00000047},   // R11 byte
        {8'd4,  1'b0, 12'h00A, 2'd0, 32'h0, 32'h00000034},   // R4 subclass
        {8'd4,  1'b0, 12'h00A, 2'd1, 32'h0, 32'h00001234},   // R4 word
        {8'd4,  1'b0, 12'h00B, 2'd0, 32'h0, 32'h00000012},   // R4 class
        {8'd5,  1'b1, 12'h010, 2'd2, 32'h0000C000, 32'h0},   // R5
        {8'd5,  1'b0, 12'h010, 2'd2, 32'h0, 32'h0000C001},   // R5 io bit set
        {8'd5,  1'b1, 12'h014, 2'd2, 32'h80000001, 32'h0},   // R5
        {8'd5,  1'b0, 12'h014, 2'd2, 32'h0, 32'h80000000},   // R5 mem bit clear
        {8'd6,  1'b1, 12'h010, 2'd2, 32'hFFFFFFFF, 32'h0},   // R6
        {8'd6,  1'b0, 12'h010, 2'd2, 32'h0, 32'hFFFFFFFD},   // R6 io mask
        {8'd6,  1'b1, 12'h014, 2'd2, 32'hFFFFFFFF, 32'h0},   // R6
        {8'd6,  1'b0, 12'h014, 2'd2, 32'h0, 32'hFFFFFF00},   // R6 mem mask
        {8'd7,  1'b1, 12'h018, 2'd2, 32'h12345678, 32'h0},   // R7
        {8'd7,  1'b0, 12'h018, 2'd2, 32'h0, 32'h00000000},   // R7 tied slot
        {8'd8,  1'b0, 12'h034, 2'd0, 32'h0, 32'h00000040},   // R8 cap ptr
        {8'd8,  1'b0, 12'h040, 2'd1, 32'h0, 32'h00005001},   // R8
        {8'd8,  1'b0, 12'h041, 2'd0, 32'h0, 32'h00000050},   // R8
        {8'd8,  1'b0, 12'h050, 2'd1, 32'h0, 32'h00007010},   // R8
        {8'd8,  1'b0, 12'h051, 2'd0, 32'h0, 32'h00000070},   // R8
        {8'd8,  1'b0, 12'h070, 2'd1, 32'h0, 32'h00000011},   // R8
        {8'd8,  1'b0, 12'h071, 2'd0, 32'h0, 32'h00000000},   // R8 end
        {8'd9,  1'b0, 12'h100, 2'd2, 32'h0, 32'h14000001},   // R9
        {8'd9,  1'b0, 12'h140, 2'd2, 32'h0, 32'h18000002},   // R9
        {8'd9,  1'b0, 12'h180, 2'd2, 32'h0, 32'h00000003},   // R9 end
        {8'd10, 1'b1, 12'h0FC, 2'd2, 32'hFFFFFFFF, 32'h0},   // R10
        {8'd10, 1'b0, 12'h0FC, 2'd2, 32'h0, 32'h00000000},   // R10
        {8'd10, 1'b0, 12'h004, 2'd2, 32'h0, 32'h00000147},   // R10 cmd kept
        {8'd10, 1'b0, 12'h010, 2'd2, 32'h0, 32'hFFFFFFFD},   // R10 bar kept
        {8'd10, 1'b0, 12'h200, 2'd2, 32'h0, 32'h00000000},   // R10
        {8'd11, 1'b0, 12'h000, 2'd0, 32'h0, 32'h000000CD},   // R11 byte
        {8'd11, 1'b0, 12'h014, 2'd1, 32'h0, 32'h0000FF00},   // R11 word
        {8'd6,  1'b1, 12'h010, 2'd2, 32'hFFFFFFFE, 32'h0},   // R6 bit0 clear
        {8'd6,  1'b0, 12'h010, 2'd2, 32'h0, 32'hFFFFFFFD}    // R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] offset = '0;
    logic [1:0]  size = 2'd2;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    cfg_space_responder uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .offset  (offset),
        .size    (size),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [11:0] ofs, input logic [1:0] sz,
                          input logic [31:0] exp);
        @(negedge clk);
        wr_en = 1'b0; offset = ofs; size = sz;
        #1 check(req, rd_data, exp);
    endtask

    // Watchdog: an overrun counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fails++;
            $display("FAIL watchdog: got %0d expected below 20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd_chk("R1", 12'h004, 2'd2, 32'h0);
        rd_chk("R1", 12'h010, 2'd2, 32'h0);
        rd_chk("R1", 12'h014, 2'd2, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en   = VEC[i][78];
            offset  = VEC[i][77:66];
            size    = VEC[i][65:64];
            wr_data = VEC[i][63:32];
            #1;
            if (!VEC[i][78]) check($sformatf("R%0d", VEC[i][86:79]), rd_data, VEC[i][31:0]);
        end

        // R12: write and readback of BAR1 in the same cycle
        @(negedge clk);
        wr_en = 1'b1; offset = 12'h014; size = 2'd2; wr_data = 32'h00004000;
        #1 check("R12", rd_data, 32'hFFFFFF00);
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R12", rd_data, 32'h00004000);

        // R1: reset in mid-run clears stored state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_chk("R1", 12'h004, 2'd2, 32'h0);
        rd_chk("R1", 12'h014, 2'd2, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule